// File: doc/BRIEF.md
# Serial Controller Interrupt Source Arbiter

This block is the interrupt front end of a FIFO-capable serial controller. The receiver, the transmitter and the modem-line monitor each report their conditions on input pins. The block latches the momentary events and masks every source with a four-bit enable register. It then drives one interrupt line and an 8-bit identification byte. The byte names the most urgent source that is both pending and enabled. Software services the reported source, re-reads the identification byte and repeats until bit 0 reads 1.

Line-status errors, modem-line changes and transmitter-holding-empty are edge events, so the block holds them in sticky flags. Each flag has its own clearing action: a read of the line status register, a read of the modem status register, or, for the holding-register flag, either a write to the holding register or an identification read that is currently reporting that source. Received-data-available and character-timeout are levels that the receive FIFO logic owns, so the block follows them directly. Every output is registered. The interrupt line and the identification byte reflect the inputs of a cycle one clock edge later.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register is 0, no flag is pending, `irq_o` is 0 and `iir_o` reads 0x01.
- R2: `iir_o[0]` is 0 exactly when some enabled source is pending and 1 otherwise. `irq_o` equals the inverse of `iir_o[0]`. Both update on the clock edge that samples the causing input.
- R3: When several sources are pending, the reported source is the highest one in this order: line status, receive data/timeout, holding-register empty, modem status. `iir_o[3:1]` carries 011 for line status, 010 for data available, 001 for holding-register empty and 000 for modem status.
- R4: With `fifo_mode_i`=1, an enabled character timeout reports code 110 in `iir_o[3:1]`, and this code wins over data available. With `fifo_mode_i`=0 the timeout input is ignored and `iir_o[3]` is 0.
- R5: `iir_o[5:4]` is always 00. `iir_o[7:6]` is 11 when `fifo_mode_i` is 1 and 00 when it is 0.
- R6: Enable bit 0 gates data available and timeout, bit 1 gates holding-register empty, bit 2 gates line status and bit 3 gates modem status. A write to the enable register acts in the same edge. An event that arrives while its enable is 0 is not latched. With all four enables at 0, `irq_o` stays 0.
- R7: A line-status event latches a flag that clears on `lsr_rd_i`. If an event and a read arrive in the same cycle, the flag stays set.
- R8: A modem-change event latches a flag that clears on `msr_rd_i`. If an event and a read arrive in the same cycle, the flag stays set.
- R9: A holding-register-empty event latches a flag. The flag clears on `thr_wr_i`, or on `iir_rd_i` while `iir_o` reports code 001 with bit 0 at 0. An identification read that reports another source leaves the flag set.
- R10: Data available and timeout are level sources. Their report follows `rx_avail_i` and `rx_timeout_i` with one cycle of latency and no latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | FIFO mode selected |
| ier_wr_i | input | 1 | Write strobe for the enable register |
| ier_wdata_i | input | 4 | Enable register write data |
| lsr_err_i | input | 1 | Receiver line-status error event (pulse) |
| rx_avail_i | input | 1 | Received data available (level) |
| rx_timeout_i | input | 1 | Character timeout condition (level) |
| thr_empty_i | input | 1 | Holding register became empty (pulse) |
| msr_chg_i | input | 1 | Modem input change event (pulse) |
| lsr_rd_i | input | 1 | Line status register read strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identification byte |

## Verification
The bench raises all four priority levels one at a time and then retires them in order. A wrong priority order or a swapped code would show up as a wrong byte at some step of that sequence. It issues an identification read while line status hides a pending holding-register flag. A design that clears that flag on any read would lose the transmitter interrupt once line status is serviced. It drives an event and its clearing read in the same cycle, which a clear-wins design would drop. It fires events while their enable bit is 0, which a design that latches raw events would later report. It toggles FIFO mode with the timeout input held high, where a design that ignores the mode would report code 110 or leave the marker bits wrong.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int EN_W    = 4;
    localparam int IIR_W   = 8;
    localparam int CODE_W  = 3;
    localparam int NFLAG   = 3;

    // enable register bit positions (decoded by software)
    localparam int EN_RX   = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;

    // sticky flag indices
    localparam int FLG_LS   = 0;
    localparam int FLG_THRE = 1;
    localparam int FLG_MS   = 2;

    // source code carried in iir[3:1]
    typedef enum logic [CODE_W-1:0] {
        SRC_MS   = 3'b000,
        SRC_THRE = 3'b001,
        SRC_RDA  = 3'b010,
        SRC_LS   = 3'b011,
        SRC_TO   = 3'b110
    } src_code_e;

    typedef struct packed {
        logic [EN_W-1:0]  ier;
        logic [NFLAG-1:0] flag;
        logic [IIR_W-1:0] iir;
        logic             irq;
    } irq_state_t;

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
    input  logic q_i,
    input  logic set_i,
    input  logic clr_i,
    output logic d_o
);
    // a new event outranks a clearing access in the same cycle
    always_comb begin
        d_o = set_i | (q_i & ~clr_i);
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic              ls_i,
    input  logic              to_i,
    input  logic              rda_i,
    input  logic              thre_i,
    input  logic              ms_i,
    output logic              any_o,
    output logic [CODE_W-1:0] code_o
);
    always_comb begin
        any_o  = ls_i | to_i | rda_i | thre_i | ms_i;
        code_o = SRC_MS;
        if (ls_i)        code_o = SRC_LS;
        else if (to_i)   code_o = SRC_TO;
        else if (rda_i)  code_o = SRC_RDA;
        else if (thre_i) code_o = SRC_THRE;
        else             code_o = SRC_MS;
    end
endmodule

// File: rtl/uart_irq_fmt.sv
module uart_irq_fmt
    import uart_irq_pkg::*;
(
    input  logic              fifo_i,
    input  logic              any_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [IIR_W-1:0]  iir_o
);
    always_comb begin
        iir_o       = '0;
        iir_o[0]    = ~any_i;
        iir_o[3:1]  = any_i ? code_i : 3'b000;
        iir_o[5:4]  = 2'b00;
        iir_o[7:6]  = {2{fifo_i}};
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode_i,
    input  logic             ier_wr_i,
    input  logic [EN_W-1:0]  ier_wdata_i,
    input  logic             lsr_err_i,
    input  logic             rx_avail_i,
    input  logic             rx_timeout_i,
    input  logic             thr_empty_i,
    input  logic             msr_chg_i,
    input  logic             lsr_rd_i,
    input  logic             msr_rd_i,
    input  logic             thr_wr_i,
    input  logic             iir_rd_i,
    output logic             irq_o,
    output logic [IIR_W-1:0] iir_o
);
    localparam logic [IIR_W-1:0] IIR_IDLE = {{(IIR_W-1){1'b0}}, 1'b1};

    irq_state_t state_d, state_q;

    logic [EN_W-1:0]   ier_nx;
    logic [NFLAG-1:0]  flag_set, flag_clr, flag_nx;
    logic              thre_reported;
    logic              any_pend;
    logic [CODE_W-1:0] win_code;
    logic [IIR_W-1:0]  iir_nx;

    always_comb begin
        ier_nx = ier_wr_i ? ier_wdata_i : state_q.ier;

        thre_reported = ~state_q.iir[0] && (state_q.iir[3:1] == SRC_THRE);

        flag_set[FLG_LS]   = lsr_err_i   & ier_nx[EN_LS];
        flag_clr[FLG_LS]   = lsr_rd_i;
        flag_set[FLG_THRE] = thr_empty_i & ier_nx[EN_THRE];
        flag_clr[FLG_THRE] = thr_wr_i | (iir_rd_i & thre_reported);
        flag_set[FLG_MS]   = msr_chg_i   & ier_nx[EN_MS];
        flag_clr[FLG_MS]   = msr_rd_i;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        uart_irq_flag i_flag (
            .q_i   (state_q.flag[g]),
            .set_i (flag_set[g]),
            .clr_i (flag_clr[g]),
            .d_o   (flag_nx[g])
        );
    end

    uart_irq_prio i_prio (
        .ls_i   (flag_nx[FLG_LS]   & ier_nx[EN_LS]),
        .to_i   (rx_timeout_i & fifo_mode_i & ier_nx[EN_RX]),
        .rda_i  (rx_avail_i & ier_nx[EN_RX]),
        .thre_i (flag_nx[FLG_THRE] & ier_nx[EN_THRE]),
        .ms_i   (flag_nx[FLG_MS]   & ier_nx[EN_MS]),
        .any_o  (any_pend),
        .code_o (win_code)
    );

    uart_irq_fmt i_fmt (
        .fifo_i (fifo_mode_i),
        .any_i  (any_pend),
        .code_i (win_code),
        .iir_o  (iir_nx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.ier  = ier_nx;
        state_d.flag = flag_nx;
        state_d.iir  = iir_nx;
        state_d.irq  = any_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ier  <= '0;
            state_q.flag <= '0;
            state_q.iir  <= IIR_IDLE;
            state_q.irq  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.irq;
    assign iir_o = state_q.iir;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_mode_i,
    input logic       ier_wr_i,
    input logic       lsr_err_i,
    input logic       msr_rd_i,
    input logic       msr_chg_i,
    input logic [3:0] ier_q,
    input logic       irq_o,
    input logic [7:0] iir_o
);
    // R2
    irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == !iir_o[0]);

    // R7
    ls_event_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_err_i && ier_q[2] && !ier_wr_i) |=> (iir_o[3:0] == 4'b0110 && irq_o));

    // R6
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == 4'b0000 && !ier_wr_i) |=> !irq_o);

    // R4
    no_timeout_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode_i |=> !iir_o[3]);

    // R5
    fifo_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode_i |=> (iir_o[7:6] == 2'b11 && iir_o[5:4] == 2'b00));

    // R8
    ms_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && !msr_chg_i) |=> (iir_o[0] || iir_o[3:1] != 3'b000));
endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode_i (fifo_mode_i),
    .ier_wr_i    (ier_wr_i),
    .lsr_err_i   (lsr_err_i),
    .msr_rd_i    (msr_rd_i),
    .msr_chg_i   (msr_chg_i),
    .ier_q       (state_q.ier),
    .irq_o       (irq_o),
    .iir_o       (iir_o)
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode_i = 1'b0;
    logic       ier_wr_i = 1'b0;
    logic [3:0] ier_wdata_i = '0;
    logic       lsr_err_i = 1'b0;
    logic       rx_avail_i = 1'b0;
    logic       rx_timeout_i = 1'b0;
    logic       thr_empty_i = 1'b0;
    logic       msr_chg_i = 1'b0;
    logic       lsr_rd_i = 1'b0;
    logic       msr_rd_i = 1'b0;
    logic       thr_wr_i = 1'b0;
    logic       iir_rd_i = 1'b0;
    logic       irq_o;
    logic [7:0] iir_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk, .rst_n, .fifo_mode_i, .ier_wr_i, .ier_wdata_i,
        .lsr_err_i, .rx_avail_i, .rx_timeout_i, .thr_empty_i, .msr_chg_i,
        .lsr_rd_i, .msr_rd_i, .thr_wr_i, .iir_rd_i, .irq_o, .iir_o
    );

    // sampled at the falling edge, after the registers settled
    task automatic check(string req, logic [7:0] exp_iir);
        logic exp_irq;
        exp_irq = ~exp_iir[0];
        n_cmp++;
        if (iir_o !== exp_iir || irq_o !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     req, iir_o, irq_o, exp_iir, exp_irq);
        end
    endtask

    // pulses driven after a falling edge span exactly one rising edge
    task automatic tick();
        @(negedge clk);
        ier_wr_i = 0; lsr_err_i = 0; thr_empty_i = 0; msr_chg_i = 0;
        lsr_rd_i = 0; msr_rd_i = 0; thr_wr_i = 0; iir_rd_i = 0;
    endtask

    task automatic set_ier(logic [3:0] v);
        ier_wr_i = 1; ier_wdata_i = v; tick();
    endtask

    task automatic t_reset();
        check("R1 reset", 8'h01);
    endtask

    task automatic t_masked();
        lsr_err_i = 1; msr_chg_i = 1; thr_empty_i = 1; rx_avail_i = 1; tick();
        check("R6 all enables off", 8'h01);
        set_ier(4'hF);
        check("R6 masked events not latched, level visible", 8'h04);
        rx_avail_i = 0; tick();
        check("R10 level source follows input", 8'h01);
        set_ier(4'b1011);
        lsr_err_i = 1; tick();
        check("R6 line status bit 2 off", 8'h01);
        set_ier(4'hF);
    endtask

    task automatic t_priority();
        msr_chg_i = 1; tick();
        check("R3 modem only", 8'h00);
        thr_empty_i = 1; tick();
        check("R3 holding empty over modem", 8'h02);
        rx_avail_i = 1; tick();
        check("R3 data over holding empty", 8'h04);
        lsr_err_i = 1; tick();
        check("R3 line status highest", 8'h06);
        lsr_rd_i = 1; tick();
        check("R7 lsr read clears", 8'h04);
        rx_avail_i = 0; tick();
        check("R10 data drops", 8'h02);
        thr_wr_i = 1; tick();
        check("R9 holding write clears", 8'h00);
        msr_rd_i = 1; tick();
        check("R8 msr read clears", 8'h01);
        check("R2 idle after service", 8'h01);
    endtask

    task automatic t_iir_read();
        thr_empty_i = 1; lsr_err_i = 1; tick();
        check("R3 line status hides holding", 8'h06);
        iir_rd_i = 1; tick();
        check("R9 read of other source keeps flag", 8'h06);
        lsr_rd_i = 1; tick();
        check("R9 holding still pending", 8'h02);
        iir_rd_i = 1; tick();
        check("R9 reporting read clears", 8'h01);
    endtask

    task automatic t_same_cycle();
        lsr_err_i = 1; lsr_rd_i = 1; tick();
        check("R7 event beats read", 8'h06);
        lsr_rd_i = 1; tick();
        msr_chg_i = 1; msr_rd_i = 1; tick();
        check("R8 event beats read", 8'h00);
        msr_rd_i = 1; tick();
        check("R8 cleared", 8'h01);
    endtask

    task automatic t_fifo();
        fifo_mode_i = 1; tick();
        check("R5 fifo marker idle", 8'hC1);
        rx_timeout_i = 1; tick();
        check("R4 timeout code", 8'hCC);
        rx_avail_i = 1; tick();
        check("R4 timeout over data", 8'hCC);
        rx_timeout_i = 0; tick();
        check("R10 data after timeout", 8'hC4);
        rx_avail_i = 0; rx_timeout_i = 1; fifo_mode_i = 0; tick();
        check("R4 timeout ignored without fifo", 8'h01);
        rx_timeout_i = 0; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_priority();
        t_iir_read();
        t_same_cycle();
        t_fifo();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule